// File: doc/BRIEF.md
# Synchronous Exception Dispatch Unit

This block takes a synchronous exception request or a debug request from the core and decides which handler vector it goes to. In the same clock edge it updates every exception-related special register. A general exception carries a cause code, the faulting program counter and, when the `exc_has_vaddr` flag is set, a faulting virtual address. A debug request carries a debug cause and the same program counter input.

The routing depends on the processor status word (PS), which has three fields:
- an interrupt-level field in bits 3:0,
- an exception-mode flag in bit 4,
- a user-mode flag in bit 5.

If a general exception arrives while exception mode is already set, it is a double exception. A debug entry is taken only when the current interrupt level is below the configured debug level. The entry saves the old PS into the save slot for that level and raises the interrupt level.

The control is a two-state machine:
- `ST_RUN` accepts requests.
- `ST_REDIR` drives the one-cycle redirect strobe.

There are two transitions. "accept" goes from `ST_RUN` to `ST_REDIR` when a request is taken. "flush" goes from `ST_REDIR` back to `ST_RUN` unconditionally. Software, or a bench, reaches the special registers through a plain indexed read/write port.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, all special registers read 0, `redirect` is low and the machine is in `ST_RUN`.
- R2: For a general exception accepted while PS bit 4 is clear, the PC is saved into the level-1 save register. The vector is user (code 1) when PS bit 5 is set, and kernel (code 0) when it is clear.
- R3: For a general exception accepted while PS bit 4 is set, the vector is double (code 2). The PC goes into the double-fault save register when `HAS_DEPC` is 1, and the level-1 save register is left unchanged.
- R4: Every accepted general exception writes its cause, zero-extended, into the cause register. It sets PS bit 4 and leaves all other PS bits unchanged.
- R5: The fault-address register is loaded from `exc_vaddr` only when `exc_has_vaddr` is 1. Otherwise it keeps its value.
- R6: A debug request is taken only when PS bits 3:0 are below `DEBUG_LEVEL`, which defaults to 6. Otherwise it changes no register and raises no strobe.
- R7: A taken debug request does all of the following, with vector code 3:
  - writes the debug-cause register,
  - saves the PC into the save register for level `DEBUG_LEVEL`,
  - saves the old PS into the PS-save register for that level,
  - sets PS bits 3:0 to `DEBUG_LEVEL`,
  - sets PS bit 4.
- R8: When a general exception and a debug request are both asserted in `ST_RUN`, only the general exception is taken, and the debug-cause register is unchanged.
- R9: `redirect` is high for exactly the one cycle after the accepting edge, and `redirect_vec` holds the chosen vector. Requests presented during that redirect cycle are ignored.
- R10: The register port has a combinational read and a write that takes effect at the next edge. A write is dropped when a request is accepted in the same cycle. Unmapped indices read 0. The index map is:

  | Index | Register |
  |---|---|
  | 0 | PS |
  | 1 | cause |
  | 2 | fault address |
  | 3 | double-fault save |
  | 4 | debug cause |
  | 7+n | PC save for level n, n = 1..7 |
  | 16+n | PS save for level n, n = 2..7 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | Exception cause code |
| req_pc | input | XLEN | Faulting PC for either request |
| exc_has_vaddr | input | 1 | Request carries a fault address |
| exc_vaddr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| rf_we | input | 1 | Register port write enable |
| rf_addr | input | 5 | Register index |
| rf_wdata | input | XLEN | Register write data |
| rf_rdata | output | XLEN | Register read data |
| redirect | output | 1 | One-cycle redirect strobe |
| redirect_vec | output | 2 | Vector: 0 kernel, 1 user, 2 double, 3 debug |

## Verification
The assertions take for granted that the request inputs are stable around the sampling edge. They also assume that `DEBUG_LEVEL` is between 2 and `NLEV`, and that the PS fields do not overlap. The bench keeps within this by changing every input only at the falling edge and by using the default parameters.

Back-to-back requests, simultaneous requests and PS values written at random through the port are all legal. The stimulus uses them on purpose to reach double exceptions, suppressed debug entries and dropped writes.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int RA_W         = 5;
    localparam int IDX_PS       = 0;
    localparam int IDX_CAUSE    = 1;
    localparam int IDX_VADDR    = 2;
    localparam int IDX_DSAVE    = 3;
    localparam int IDX_DCAUSE   = 4;
    localparam int IDX_EPC_BASE = 7;
    localparam int IDX_EPS_BASE = 16;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } vec_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_REDIR = 1'b1
    } st_e;

    typedef struct packed {
        logic take_exc;
        logic take_dbg;
        logic to_dsave;
        vec_e vec;
    } route_t;
endpackage

// File: rtl/exc_route.sv
module exc_route import exc_pkg::*; #(
    parameter int IL_W        = 4,
    parameter int DEBUG_LEVEL = 6,
    parameter bit HAS_DEPC    = 1'b1
) (
    input  logic            armed,
    input  logic            exc_req,
    input  logic            dbg_req,
    input  logic            ps_excm,
    input  logic            ps_um,
    input  logic [IL_W-1:0] ps_il,
    output route_t          route
);
    localparam logic [IL_W-1:0] DL = IL_W'(DEBUG_LEVEL);

    logic dbg_ok;
    assign dbg_ok = (ps_il < DL);

    always_comb begin
        route.take_exc = armed & exc_req;
        route.take_dbg = armed & ~exc_req & dbg_req & dbg_ok;
        route.to_dsave = armed & exc_req & ps_excm & HAS_DEPC;
        if (route.take_dbg)
            route.vec = VEC_DEBUG;
        else if (ps_excm)
            route.vec = VEC_DOUBLE;
        else if (ps_um)
            route.vec = VEC_USER;
        else
            route.vec = VEC_KERNEL;
    end
endmodule

// File: rtl/exc_sreg_file.sv
module exc_sreg_file import exc_pkg::*; #(
    parameter int XLEN        = 32,
    parameter int NLEV        = 7,
    parameter int DEBUG_LEVEL = 6,
    parameter int IL_LSB      = 0,
    parameter int IL_W        = 4,
    parameter int EXCM_BIT    = 4,
    parameter int CAUSE_W     = 6,
    parameter int DCAUSE_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  route_t              route,
    input  logic [XLEN-1:0]     req_pc,
    input  logic [CAUSE_W-1:0]  exc_cause,
    input  logic                exc_has_vaddr,
    input  logic [XLEN-1:0]     exc_vaddr,
    input  logic [DCAUSE_W-1:0] dbg_cause,
    input  logic                rf_we,
    input  logic [RA_W-1:0]     rf_addr,
    input  logic [XLEN-1:0]     rf_wdata,
    output logic [XLEN-1:0]     rf_rdata,
    output logic [XLEN-1:0]     ps_q
);
    localparam logic [XLEN-1:0] IL_MASK  = XLEN'((1 << IL_W) - 1) << IL_LSB;
    localparam logic [XLEN-1:0] EXCM_M   = XLEN'(1) << EXCM_BIT;
    localparam logic [XLEN-1:0] DBG_BITS = (XLEN'(DEBUG_LEVEL) << IL_LSB) | EXCM_M;

    logic [XLEN-1:0] cause_q, vaddr_q, dsave_q, dcause_q;
    logic [XLEN-1:0] epc_q [1:NLEV];
    logic [XLEN-1:0] eps_q [2:NLEV];
    logic            sw_we;

    assign sw_we = rf_we & ~(route.take_exc | route.take_dbg);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q     <= '0;
            cause_q  <= '0;
            vaddr_q  <= '0;
            dsave_q  <= '0;
            dcause_q <= '0;
        end else if (route.take_exc) begin
            ps_q    <= ps_q | EXCM_M;
            cause_q <= XLEN'(exc_cause);
            if (exc_has_vaddr)
                vaddr_q <= exc_vaddr;
            if (route.to_dsave)
                dsave_q <= req_pc;
        end else if (route.take_dbg) begin
            ps_q     <= (ps_q & ~IL_MASK) | DBG_BITS;
            dcause_q <= XLEN'(dbg_cause);
        end else if (sw_we) begin
            if (rf_addr == RA_W'(IDX_PS))     ps_q     <= rf_wdata;
            if (rf_addr == RA_W'(IDX_CAUSE))  cause_q  <= rf_wdata;
            if (rf_addr == RA_W'(IDX_VADDR))  vaddr_q  <= rf_wdata;
            if (rf_addr == RA_W'(IDX_DSAVE))  dsave_q  <= rf_wdata;
            if (rf_addr == RA_W'(IDX_DCAUSE)) dcause_q <= rf_wdata;
        end
    end

    for (genvar n = 1; n <= NLEV; n++) begin : g_epc
        logic [XLEN-1:0] lvl_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= '0;
            else if ((n == 1) && route.take_exc && !route.to_dsave)
                lvl_q <= req_pc;
            else if ((n == DEBUG_LEVEL) && route.take_dbg)
                lvl_q <= req_pc;
            else if (sw_we && rf_addr == RA_W'(IDX_EPC_BASE + n))
                lvl_q <= rf_wdata;
        end
        assign epc_q[n] = lvl_q;
    end

    for (genvar n = 2; n <= NLEV; n++) begin : g_eps
        logic [XLEN-1:0] lvl_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= '0;
            else if ((n == DEBUG_LEVEL) && route.take_dbg)
                lvl_q <= ps_q;
            else if (sw_we && rf_addr == RA_W'(IDX_EPS_BASE + n))
                lvl_q <= rf_wdata;
        end
        assign eps_q[n] = lvl_q;
    end

    always_comb begin
        rf_rdata = '0;
        if (rf_addr == RA_W'(IDX_PS))     rf_rdata = ps_q;
        if (rf_addr == RA_W'(IDX_CAUSE))  rf_rdata = cause_q;
        if (rf_addr == RA_W'(IDX_VADDR))  rf_rdata = vaddr_q;
        if (rf_addr == RA_W'(IDX_DSAVE))  rf_rdata = dsave_q;
        if (rf_addr == RA_W'(IDX_DCAUSE)) rf_rdata = dcause_q;
        for (int n = 1; n <= NLEV; n++)
            if (rf_addr == RA_W'(IDX_EPC_BASE + n)) rf_rdata = epc_q[n];
        for (int n = 2; n <= NLEV; n++)
            if (rf_addr == RA_W'(IDX_EPS_BASE + n)) rf_rdata = eps_q[n];
    end

    p_excm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        route.take_exc |=> ps_q[EXCM_BIT]);
    p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        route.take_exc |=> cause_q == XLEN'($past(exc_cause)));
    p_vaddr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (route.take_exc && !exc_has_vaddr) |=> $stable(vaddr_q));
    p_dbg_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        route.take_dbg |=> (ps_q[IL_LSB +: IL_W] == IL_W'(DEBUG_LEVEL)) && ps_q[EXCM_BIT]);
    p_eps_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        route.take_dbg |=> eps_q[DEBUG_LEVEL] == $past(ps_q));
    p_dsave_keep_epc1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        route.to_dsave |=> $stable(epc_q[1]));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch import exc_pkg::*; #(
    parameter int XLEN        = 32,
    parameter int NLEV        = 7,
    parameter int DEBUG_LEVEL = 6,
    parameter bit HAS_DEPC    = 1'b1,
    parameter int IL_LSB      = 0,
    parameter int IL_W        = 4,
    parameter int EXCM_BIT    = 4,
    parameter int UM_BIT      = 5,
    parameter int CAUSE_W     = 6,
    parameter int DCAUSE_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exc_req,
    input  logic [CAUSE_W-1:0]  exc_cause,
    input  logic [XLEN-1:0]     req_pc,
    input  logic                exc_has_vaddr,
    input  logic [XLEN-1:0]     exc_vaddr,
    input  logic                dbg_req,
    input  logic [DCAUSE_W-1:0] dbg_cause,
    input  logic                rf_we,
    input  logic [4:0]          rf_addr,
    input  logic [XLEN-1:0]     rf_wdata,
    output logic [XLEN-1:0]     rf_rdata,
    output logic                redirect,
    output logic [1:0]          redirect_vec
);
    st_e             state_q, state_d;
    vec_e            vec_q;
    route_t          route;
    logic [XLEN-1:0] ps_q;
    logic            accept;

    exc_route #(
        .IL_W(IL_W), .DEBUG_LEVEL(DEBUG_LEVEL), .HAS_DEPC(HAS_DEPC)
    ) u_route (
        .armed   (state_q == ST_RUN),
        .exc_req (exc_req),
        .dbg_req (dbg_req),
        .ps_excm (ps_q[EXCM_BIT]),
        .ps_um   (ps_q[UM_BIT]),
        .ps_il   (ps_q[IL_LSB +: IL_W]),
        .route   (route)
    );

    exc_sreg_file #(
        .XLEN(XLEN), .NLEV(NLEV), .DEBUG_LEVEL(DEBUG_LEVEL), .IL_LSB(IL_LSB),
        .IL_W(IL_W), .EXCM_BIT(EXCM_BIT), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W)
    ) u_sregs (
        .clk           (clk),
        .rst_n         (rst_n),
        .route         (route),
        .req_pc        (req_pc),
        .exc_cause     (exc_cause),
        .exc_has_vaddr (exc_has_vaddr),
        .exc_vaddr     (exc_vaddr),
        .dbg_cause     (dbg_cause),
        .rf_we         (rf_we),
        .rf_addr       (rf_addr),
        .rf_wdata      (rf_wdata),
        .rf_rdata      (rf_rdata),
        .ps_q          (ps_q)
    );

    assign accept = route.take_exc | route.take_dbg;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = accept ? ST_REDIR : ST_RUN;
            ST_REDIR: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= VEC_KERNEL;
        else if (accept) vec_q <= route.vec;
    end

    assign redirect     = (state_q == ST_REDIR);
    assign redirect_vec = vec_q;

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);
    p_dbg_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && vec_q == VEC_DEBUG) |-> $past(ps_q[IL_LSB +: IL_W]) < IL_W'(DEBUG_LEVEL));
    p_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && vec_q == VEC_DOUBLE) |-> $past(ps_q[EXCM_BIT]));
    p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && exc_req) |=> (redirect && vec_q != VEC_DEBUG));
endmodule

// File: tb/exc_dispatch_bench.sv
`timescale 1ns/1ps
module exc_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 0, exc_has_vaddr = 0, dbg_req = 0, rf_we = 0;
    logic [5:0]  exc_cause = 0, dbg_cause = 0;
    logic [31:0] req_pc = 0, exc_vaddr = 0, rf_wdata = 0;
    logic [4:0]  rf_addr = 0;
    logic [31:0] rf_rdata;
    logic        redirect;
    logic [1:0]  redirect_vec;

    always #2.5 clk = ~clk;

    exc_dispatch u_exc_dispatch (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .req_pc(req_pc), .exc_has_vaddr(exc_has_vaddr), .exc_vaddr(exc_vaddr),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .redirect(redirect), .redirect_vec(redirect_vec)
    );

    int    checks = 0, fails = 0;
    bit    done = 0;
    string tag = "R1";

    // behavioural reference state
    logic [31:0] m_ps, m_cause, m_va, m_dsave, m_dc;
    logic [31:0] m_epc [1:7];
    logic [31:0] m_eps [2:7];
    bit          m_redir;
    logic [1:0]  m_vec;

    task automatic model_reset();
        m_ps = 0; m_cause = 0; m_va = 0; m_dsave = 0; m_dc = 0;
        for (int i = 1; i <= 7; i++) m_epc[i] = 0;
        for (int i = 2; i <= 7; i++) m_eps[i] = 0;
        m_redir = 0; m_vec = 0;
    endtask

    function automatic logic [31:0] mread(input int a);
        if (a == 0) return m_ps;
        if (a == 1) return m_cause;
        if (a == 2) return m_va;
        if (a == 3) return m_dsave;
        if (a == 4) return m_dc;
        if (a >= 8 && a <= 14) return m_epc[a-7];
        if (a >= 18 && a <= 23) return m_eps[a-16];
        return 0;
    endfunction

    task automatic mwrite(input int a, input logic [31:0] d);
        if (a == 0) m_ps = d;
        if (a == 1) m_cause = d;
        if (a == 2) m_va = d;
        if (a == 3) m_dsave = d;
        if (a == 4) m_dc = d;
        if (a >= 8 && a <= 14) m_epc[a-7] = d;
        if (a >= 18 && a <= 23) m_eps[a-16] = d;
    endtask

    task automatic model_edge();
        bit nr = 0;
        if (!m_redir && exc_req) begin
            if (exc_has_vaddr) m_va = exc_vaddr;
            if (m_ps[4]) begin m_dsave = req_pc; m_vec = 2; end
            else begin m_epc[1] = req_pc; m_vec = m_ps[5] ? 2'd1 : 2'd0; end
            m_cause = {26'd0, exc_cause};
            m_ps[4] = 1'b1;
            nr = 1;
        end else if (!m_redir && dbg_req && m_ps[3:0] < 4'd6) begin
            m_dc = {26'd0, dbg_cause};
            m_epc[6] = req_pc;
            m_eps[6] = m_ps;
            m_ps = {m_ps[31:5], 1'b1, 4'd6};
            m_vec = 3;
            nr = 1;
        end else if (rf_we) begin
            mwrite(int'(rf_addr), rf_wdata);
        end
        m_redir = nr;
    endtask

    task automatic chk(input string t, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", t, what, got, exp);
        end
    endtask

    // one clock: model steps with the design, outputs compared at the falling edge
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "redirect (R9)", {31'd0, redirect}, {31'd0, m_redir});
        if (m_redir) chk(tag, "vector (R9)", {30'd0, redirect_vec}, {30'd0, m_vec});
        chk(tag, "rdata", rf_rdata, mread(int'(rf_addr)));
        exc_req = 0; dbg_req = 0; rf_we = 0; exc_has_vaddr = 0;
    endtask

    task automatic sweep();
        for (int a = 0; a < 32; a++) begin
            rf_addr = a[4:0];
            #0.05;
            chk(tag, $sformatf("reg[%0d]", a), rf_rdata, mread(a));
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        rf_we = 1; rf_addr = a[4:0]; rf_wdata = d; cycle();
    endtask

    task automatic gen_exc(input logic [5:0] c, input logic [31:0] pc, input bit hv, input logic [31:0] va);
        exc_req = 1; exc_cause = c; req_pc = pc; exc_has_vaddr = hv; exc_vaddr = va;
        cycle(); cycle();
    endtask

    task automatic gen_dbg(input logic [5:0] c, input logic [31:0] pc);
        dbg_req = 1; dbg_cause = c; req_pc = pc;
        cycle(); cycle();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1";
        chk(tag, "redirect after reset", {31'd0, redirect}, 32'd0);
        sweep();

        tag = "R2";
        gen_exc(6'd9, 32'h1000_0040, 1, 32'hDEAD_0000);
        sweep();

        tag = "R2";
        wr(0, 32'h0000_0020);
        gen_exc(6'd3, 32'h2000_0010, 0, 32'h0);
        sweep();

        tag = "R3";
        gen_exc(6'd5, 32'h3000_0100, 1, 32'hBEEF_0004);
        sweep();

        tag = "R5";
        gen_exc(6'd7, 32'h3000_0200, 0, 32'h1234_5678);
        rf_addr = 5'd2; #0.05;
        chk(tag, "vaddr kept", rf_rdata, 32'hBEEF_0004);

        tag = "R7";
        wr(0, 32'h0000_0002);
        gen_dbg(6'd4, 32'h4000_0000);
        sweep();

        tag = "R6";
        gen_dbg(6'd1, 32'h4000_0080);
        sweep();
        wr(0, 32'h0000_0007);
        gen_dbg(6'd2, 32'h4000_00C0);
        sweep();
        wr(0, 32'h0000_0005);
        gen_dbg(6'd8, 32'h4000_0100);
        sweep();

        tag = "R8";
        wr(0, 32'h0);
        exc_req = 1; dbg_req = 1; exc_cause = 6'd11; dbg_cause = 6'd33; req_pc = 32'h5000_0000;
        cycle(); cycle();
        sweep();

        tag = "R9";
        wr(0, 32'h0);
        exc_req = 1; exc_cause = 6'd12; req_pc = 32'h6000_0000; cycle();
        exc_req = 1; exc_cause = 6'd13; req_pc = 32'h6000_0004; cycle();
        cycle();
        sweep();

        tag = "R10";
        exc_req = 1; exc_cause = 6'd14; req_pc = 32'h7000_0000;
        rf_we = 1; rf_addr = 5'd4; rf_wdata = 32'hFFFF_FFFF;
        cycle(); cycle();
        sweep();

        tag = "R10 random";
        for (int i = 0; i < 600; i++) begin
            exc_req = ($urandom % 5) == 0;
            dbg_req = ($urandom % 4) == 0;
            exc_cause = 6'($urandom); dbg_cause = 6'($urandom);
            req_pc = $urandom; exc_vaddr = $urandom;
            exc_has_vaddr = 1'($urandom);
            rf_we = ($urandom % 3) == 0;
            rf_addr = 5'($urandom);
            rf_wdata = ($urandom % 2) ? 32'($urandom % 64) : $urandom;
            cycle();
        end
        sweep();

        done = 1;
        summary();
        $finish;
    end
endmodule